// File: doc/BRIEF.md
# SDRAM Data Mask and Read Latency Aligner

This block sits between a memory controller's command sequencer and the data pins of a 72-bit SDRAM data bus. That bus has nine byte lanes: eight data lanes and one check-bit lane. The sequencer tells the block when a read or write burst is issued, when a burst stop is issued, the burst length and the CAS latency in use. The host supplies one mask bit per byte for every beat. From these inputs the block produces the eight DQM lines, the enable that lets the controller drive the data bus, and a strobe marking the clock in which read data is on the pins, together with the byte mask for that data.

A write beat's mask is applied to the DQM lines in the same clock as the beat, because the memory samples DQM with the write data. A read beat's mask must reach the memory two clocks before the data it masks leaves the memory, so the block delays the mask by the CAS latency minus two. The read-valid strobe and its byte mask are delayed by the full CAS latency. The check-bit lane has no DQM line of its own and follows one of the eight data mask lines. The block drops the write drive enable in the clock before read data arrives and in the clock the data arrives, so the two directions never share a cycle on the bus.

Top module: `sdram_dq_align`

## Requirements
- R1: While reset is asserted and right after it, dqm, wrDrive, rdValid and rdMask are all zero.
- R2: A write issue starts a write burst whose beats are the issue clock and the following clocks, for a total of 1, 2, 4 or 8 beats when blCode is 0, 1, 2 or 3. wrDrive is high in each such beat unless R9 suppresses it.
- R3: In every clock where wrDrive is high, dqm equals hostMask of that same clock (write mask latency 0).
- R4: Each read beat (the read issue clock and the following beats of the burst, counted as in R2) yields rdValid high exactly CL clocks later, where CL is 2 when casLat is 0 and 3 when casLat is 1.
- R5: When wrDrive is low, dqm carries the hostMask of the read beat issued CL minus 2 clocks earlier, so that the mask acts on the data two clocks later.
- R6: In a clock with rdValid high, rdMask[7:0] equals the hostMask of the matching read beat and rdMask[8] (the check-bit lane) copies bit 7 of it. rdMask is zero whenever rdValid is low.
- R7: A burst stop with no issue in the same clock ends the current burst: that clock and later clocks are not beats. At most CL-1 rdValid clocks follow the stop clock.
- R8: A new issue ends any burst in progress. When a read issue and a write issue arrive in the same clock, the read wins and no write beat occurs.
- R9: wrDrive is low in every clock where rdValid is high and in the clock before it.
- R10: dqm is zero in any clock with neither a driven write beat nor a read mask slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdIssue | input | 1 | Read burst issued this clock |
| wrIssue | input | 1 | Write burst issued this clock |
| stopIssue | input | 1 | Burst stop issued this clock |
| blCode | input | 2 | Burst length code: beats = 2^blCode |
| casLat | input | 1 | 0 selects CAS latency 2, 1 selects 3 |
| hostMask | input | 8 | Per-byte host mask for the current beat, 1 = masked |
| dqm | output | 8 | Mask lines to the memory |
| wrDrive | output | 1 | Controller drives the data bus |
| rdValid | output | 1 | Read data is on the bus this clock |
| rdMask | output | 9 | Byte mask for the read data, lane 8 = check bits |

## Verification
A corrupted beat counter shows at the ports in the next clock: wrDrive stays high past the burst length, or a read burst yields too many rdValid clocks CL later. A wrong stage in the latency pipeline shows as rdValid, the delayed dqm slot or rdMask one clock early or late. A failed guard shows as wrDrive high next to a read-valid clock. The bench compares every output in every clock against an independent model, so each of these faults is reported in the first clock it reaches a port.

// File: rtl/sdram_dq_pkg.sv
package sdram_dq_pkg;

  typedef struct packed {
    logic rdBeat;
    logic wrBeat;
  } beatStrobes_t;

  typedef enum logic [1:0] {
    DIR_IDLE = 2'd0,
    DIR_RD   = 2'd1,
    DIR_WR   = 2'd2
  } burstDir_e;

endpackage

// File: rtl/dq_beat_ctrl.sv
module dq_beat_ctrl
  import sdram_dq_pkg::*;
#(
  parameter int BL_CODE_W = 2,
  parameter int MAX_BURST = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rdIssue,
  input  logic                 wrIssue,
  input  logic                 stopIssue,
  input  logic [BL_CODE_W-1:0] blCode,
  output beatStrobes_t         beat
);

  localparam int CNT_W = $clog2(MAX_BURST) + 1;

  logic [CNT_W-1:0] remQ;
  burstDir_e        dirQ;
  logic             contBurst;
  logic [CNT_W-1:0] burstLen;

  assign burstLen  = CNT_W'(1) << blCode;
  assign contBurst = (remQ != '0) && !stopIssue;

  // Read has priority over write when both arrive together.
  always_comb begin
    beat.rdBeat = rdIssue || (!wrIssue && (dirQ == DIR_RD) && contBurst);
    beat.wrBeat = !rdIssue && (wrIssue || ((dirQ == DIR_WR) && contBurst));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remQ <= '0;
      dirQ <= DIR_IDLE;
    end else if (rdIssue) begin
      remQ <= burstLen - CNT_W'(1);
      dirQ <= DIR_RD;
    end else if (wrIssue) begin
      remQ <= burstLen - CNT_W'(1);
      dirQ <= DIR_WR;
    end else if (stopIssue) begin
      remQ <= '0;
      dirQ <= DIR_IDLE;
    end else if (remQ != '0) begin
      remQ <= remQ - CNT_W'(1);
      if (remQ == CNT_W'(1)) dirQ <= DIR_IDLE;
    end
  end

  // R8: never a read beat and a write beat together
  p_one_dir_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({beat.rdBeat, beat.wrBeat}));

  // R7: after a bare stop, no beat until a new issue
  p_stop_ends_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stopIssue && !rdIssue && !wrIssue) && !rdIssue && !wrIssue)
      |-> (!beat.rdBeat && !beat.wrBeat));

  // R2: the counter never exceeds one burst
  p_rem_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    remQ < CNT_W'(MAX_BURST));

endmodule

// File: rtl/dq_mask_pipe.sv
module dq_mask_pipe
  import sdram_dq_pkg::*;
#(
  parameter int LANES    = 9,
  parameter int MASK_W   = 8,
  parameter int ECC_LINE = 7,
  parameter int CL_LO    = 2,
  parameter int CL_HI    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  beatStrobes_t      beat,
  input  logic              casLat,
  input  logic [MASK_W-1:0] hostMask,
  output logic [MASK_W-1:0] dqm,
  output logic              wrDrive,
  output logic              rdValid,
  output logic [LANES-1:0]  rdMask
);

  localparam int DEPTH       = CL_HI;
  localparam int RD_MASK_LAT = 2;
  localparam int IDX_W       = $clog2(DEPTH + 1);

  logic [DEPTH:0]    vldAll;
  logic [MASK_W-1:0] mskAll [0:DEPTH];
  logic [IDX_W-1:0]  clIdx;
  logic [IDX_W-1:0]  slotIdx;
  logic [IDX_W-1:0]  guardIdx;
  logic              guard;
  logic [MASK_W-1:0] rdLines;

  assign vldAll[0] = beat.rdBeat;
  assign mskAll[0] = hostMask;

  genvar s;
  generate
    for (s = 1; s <= DEPTH; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rstN) begin
          vldAll[s] <= 1'b0;
          mskAll[s] <= '0;
        end else begin
          vldAll[s] <= vldAll[s-1];
          mskAll[s] <= mskAll[s-1];
        end
      end
    end
  endgenerate

  assign clIdx    = casLat ? IDX_W'(CL_HI) : IDX_W'(CL_LO);
  assign slotIdx  = clIdx - IDX_W'(RD_MASK_LAT);
  assign guardIdx = clIdx - IDX_W'(1);
  assign guard    = vldAll[clIdx] || vldAll[guardIdx];

  always_comb begin
    wrDrive = beat.wrBeat && !guard;
    rdValid = vldAll[clIdx];
    rdLines = rdValid ? mskAll[clIdx] : '0;
    if (wrDrive)               dqm = hostMask;
    else if (vldAll[slotIdx])  dqm = mskAll[slotIdx];
    else                       dqm = '0;
  end

  genvar l;
  generate
    for (l = 0; l < LANES; l++) begin : g_lane
      localparam int SRC = (l < MASK_W) ? l : ECC_LINE;
      assign rdMask[l] = rdLines[SRC];
    end
  endgenerate

  // R9: bus never driven while read data is on it
  p_no_clash_r9: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> !wrDrive);

  // R9: one clock of turnaround before read data
  p_turnaround_r9: assert property (@(posedge clk) disable iff (!rstN)
    vldAll[guardIdx] |-> !wrDrive);

  // R4: latency 2
  p_cl2_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!casLat && beat.rdBeat) |-> ##2 rdValid);

  // R4: latency 3
  p_cl3_r4: assert property (@(posedge clk) disable iff (!rstN)
    (casLat && beat.rdBeat) |-> ##3 rdValid);

  // R6: no read mask outside valid clocks
  p_rdmask_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> (rdMask == '0));

  // R3: write mask applies in the beat's own clock
  p_wr_mask_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrDrive |-> (dqm == hostMask));

endmodule

// File: rtl/sdram_dq_align.sv
module sdram_dq_align
  import sdram_dq_pkg::*;
#(
  parameter int LANES     = 9,
  parameter int MASK_W    = 8,
  parameter int ECC_LINE  = 7,
  parameter int BL_CODE_W = 2,
  parameter int MAX_BURST = 8,
  parameter int CL_LO     = 2,
  parameter int CL_HI     = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rdIssue,
  input  logic                 wrIssue,
  input  logic                 stopIssue,
  input  logic [BL_CODE_W-1:0] blCode,
  input  logic                 casLat,
  input  logic [MASK_W-1:0]    hostMask,
  output logic [MASK_W-1:0]    dqm,
  output logic                 wrDrive,
  output logic                 rdValid,
  output logic [LANES-1:0]     rdMask
);

  beatStrobes_t beat;

  dq_beat_ctrl #(
    .BL_CODE_W(BL_CODE_W),
    .MAX_BURST(MAX_BURST)
  ) ctrl_i (
    .clk(clk),
    .rstN(rstN),
    .rdIssue(rdIssue),
    .wrIssue(wrIssue),
    .stopIssue(stopIssue),
    .blCode(blCode),
    .beat(beat)
  );

  dq_mask_pipe #(
    .LANES(LANES),
    .MASK_W(MASK_W),
    .ECC_LINE(ECC_LINE),
    .CL_LO(CL_LO),
    .CL_HI(CL_HI)
  ) pipe_i (
    .clk(clk),
    .rstN(rstN),
    .beat(beat),
    .casLat(casLat),
    .hostMask(hostMask),
    .dqm(dqm),
    .wrDrive(wrDrive),
    .rdValid(rdValid),
    .rdMask(rdMask)
  );

endmodule

// File: tb/sdram_dq_align_tb.sv
module sdram_dq_align_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rdIssue = 1'b0, wrIssue = 1'b0, stopIssue = 1'b0;
  logic [1:0] blCode = 2'd0;
  logic       casLat = 1'b0;
  logic [7:0] hostMask = 8'h00;
  logic [7:0] dqm;
  logic       wrDrive, rdValid;
  logic [8:0] rdMask;

  int checks = 0;
  int errors = 0;

  // bench model state
  int         mRem = 0;
  int         mDir = 0;   // 0 idle, 1 read, 2 write
  bit         hv [0:3];
  bit [7:0]   hm [0:3];
  bit         lastValid;

  always #2.5 clk = ~clk;

  sdram_dq_align dut_i (
    .clk(clk), .rstN(rstN), .rdIssue(rdIssue), .wrIssue(wrIssue),
    .stopIssue(stopIssue), .blCode(blCode), .casLat(casLat),
    .hostMask(hostMask), .dqm(dqm), .wrDrive(wrDrive),
    .rdValid(rdValid), .rdMask(rdMask)
  );

  function automatic bit [8:0] expand(input bit [7:0] m);
    return {m[7], m};
  endfunction

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: drive at falling edge, compare before the rising edge, update model
  task automatic step(input bit rd, input bit wr, input bit stp,
                      input bit [1:0] bl, input bit [7:0] msk);
    int cl;
    bit cont, rdB, wrB, guard, expWr, expVld;
    bit [7:0] expDqm;
    @(negedge clk);
    rdIssue = rd; wrIssue = wr; stopIssue = stp; blCode = bl; hostMask = msk;
    #1.5;
    cl    = casLat ? 3 : 2;
    cont  = (mRem > 0) && !stp;
    rdB   = rd || (!wr && mDir == 1 && cont);
    wrB   = !rd && (wr || (mDir == 2 && cont));
    hv[0] = rdB; hm[0] = msk;
    expVld = hv[cl];
    guard  = hv[cl] || hv[cl-1];
    expWr  = wrB && !guard;
    if (expWr)          expDqm = msk;
    else if (hv[cl-2])  expDqm = hm[cl-2];
    else                expDqm = 8'h00;
    chk("R2/R9 wrDrive", {8'h00, wrDrive}, {8'h00, expWr});
    chk("R4 rdValid", {8'h00, rdValid}, {8'h00, expVld});
    chk(expWr ? "R3 dqm" : (hv[cl-2] ? "R5 dqm" : "R10 dqm"), {1'b0, dqm}, {1'b0, expDqm});
    chk("R6 rdMask", rdMask, expVld ? expand(hm[cl]) : 9'h000);
    lastValid = rdValid;
    if (rd)       begin mDir = 1; mRem = (1 << bl) - 1; end
    else if (wr)  begin mDir = 2; mRem = (1 << bl) - 1; end
    else if (stp) begin mDir = 0; mRem = 0; end
    else if (mRem > 0) begin mRem--; if (mRem == 0) mDir = 0; end
    for (int i = 3; i > 0; i--) begin hv[i] = hv[i-1]; hm[i] = hm[i-1]; end
  endtask

  task automatic idle(input int n, input bit newCl);
    for (int i = 0; i < n; i++) step(0, 0, 0, 2'd0, 8'h00);
    @(negedge clk);
    casLat = newCl;
  endtask

  initial begin
    int vAfter;
    bit [31:0] r;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4; i++) begin hv[i] = 0; hm[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 dqm", {1'b0, dqm}, 9'h000);
    chk("R1 wrDrive", {8'h00, wrDrive}, 9'h000);
    chk("R1 rdValid", {8'h00, rdValid}, 9'h000);
    chk("R1 rdMask", rdMask, 9'h000);
    @(negedge clk);
    rstN = 1'b1;

    // R2 R3: write burst of four with changing masks
    step(0, 1, 0, 2'd2, 8'hA5);
    step(0, 0, 0, 2'd2, 8'h3C);
    step(0, 0, 0, 2'd2, 8'h01);
    step(0, 0, 0, 2'd2, 8'h80);
    step(0, 0, 0, 2'd2, 8'hFF);  // R2: fifth clock must not drive
    idle(5, 1'b0);

    // R4 R5 R6: read CL2, burst of four
    step(1, 0, 0, 2'd2, 8'h81);
    step(0, 0, 0, 2'd2, 8'h42);
    step(0, 0, 0, 2'd2, 8'h24);
    step(0, 0, 0, 2'd2, 8'h18);
    idle(6, 1'b1);

    // R4: read CL3, burst of eight, followed at once by a write (R9)
    step(1, 0, 0, 2'd3, 8'h7F);
    for (int i = 1; i < 8; i++) step(0, 0, 0, 2'd3, 8'(i * 37));
    step(0, 1, 0, 2'd1, 8'h0F);
    step(0, 0, 0, 2'd1, 8'hF0);
    idle(6, 1'b1);

    // R7: stop in the middle of a CL3 read of eight
    step(1, 0, 0, 2'd3, 8'h11);
    step(0, 0, 0, 2'd3, 8'h22);
    step(0, 0, 0, 2'd3, 8'h33);
    step(0, 0, 1, 2'd3, 8'h44);
    vAfter = 0;
    for (int i = 0; i < 8; i++) begin
      step(0, 0, 0, 2'd3, 8'h55);
      if (lastValid) vAfter++;
    end
    chk("R7 beats after stop", 9'(vAfter), 9'd2);
    idle(4, 1'b0);

    // R8: read and write together, read wins; then write interrupting read
    step(1, 1, 0, 2'd1, 8'hC3);
    step(0, 0, 0, 2'd1, 8'h3C);
    step(0, 0, 0, 2'd0, 8'h00);
    step(1, 0, 0, 2'd3, 8'h06);
    step(0, 1, 0, 2'd0, 8'h60);
    idle(6, 1'b0);

    // random traffic; latency changes only after idle gaps
    for (int blk = 0; blk < 12; blk++) begin
      for (int i = 0; i < 300; i++) begin
        r = $urandom;
        step(r[3:0] < 3, r[7:4] < 3, r[11:8] == 0, r[13:12], r[21:14]);
      end
      idle(10, blk[0]);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule